// File: doc/BRIEF.md
# ADC Output Code Selector

This block sits between a converter core and the output pins. Every conversion result arrives as a 12-bit offset-binary word. The block re-encodes it into the code the host has chosen and registers it for the pin drivers, so the output lags the input by one clock. The choice of code is either offset binary, two's complement or Gray code.

The host programs a byte-wide control register through a simple write port. The register holds a 3-bit format field and a 3-bit driver-mode field. The format field uses one bit per code. When the field is all zeros, the code is taken from a three-level strap pin instead, which arrives already resolved into a 2-bit level.

The block stores the driver-mode field and brings it out unchanged for the pad logic. The block has two resets. A hard reset clears the whole block. A soft reset flushes only the output register and leaves both fields as they were.

Top module: `adc_fmt_sel`

## Requirements
- R1: While `rst` is high at a clock edge, `fmt_field` and `drv_mode` become 000 and `out_valid` and `out_data` become zero.
- R2: A write with `wr_en` high and `wr_addr` equal to CTRL_ADDR (default 0x1A) loads `wr_data[2:0]` into `fmt_field` and `wr_data[6:4]` into `drv_mode`. Writes to any other address leave both fields unchanged.
- R3: Format field 001 gives two's complement: the output is the input with bit 11 inverted.
- R4: Format field 010 gives Gray code: the output is the input XOR the input shifted right by one bit.
- R5: Format field 100 gives offset binary: the output equals the input.
- R6: Format field 000 hands the choice to `strap_lvl`. Level 00 (low) gives offset binary, 01 (mid) gives two's complement, 10 (high) gives Gray code, and the unused code 11 gives offset binary.
- R7: Format field values 011, 101, 110 and 111 give offset binary, whatever the strap level is.
- R8: `out_valid` equals `smp_valid` one clock earlier. `out_data` carries the converted sample one clock after it is presented, and it holds its value in cycles without a valid sample.
- R9: `soft_rst` clears `out_valid` and `out_data` to zero at the next edge. It leaves `fmt_field`, `drv_mode` and the conversion applied to later samples unchanged.
- R10: `drv_mode` presents the stored driver-mode field (000 strap, 001 LVDS 2 mA, 010 LVDS 3 mA, 100 LVCMOS) without alteration.
- R11: A new format applies to samples presented in the cycle after the write. A sample presented in the same cycle as the write is converted with the previous format.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample and register clock |
| rst | input | 1 | Hard reset, synchronous, active high |
| soft_rst | input | 1 | Soft reset, flushes the output register only |
| wr_en | input | 1 | Control write strobe |
| wr_addr | input | 8 | Control write address |
| wr_data | input | 8 | Control write data |
| strap_lvl | input | 2 | Resolved strap level: 00 low, 01 mid, 10 high |
| smp_valid | input | 1 | Input sample valid |
| smp_data | input | 12 | Offset-binary conversion result |
| out_valid | output | 1 | Output sample valid |
| out_data | output | 12 | Re-encoded sample |
| fmt_field | output | 3 | Stored format field |
| drv_mode | output | 3 | Stored driver-mode field |

## Verification
The bench drives each of the four strap levels with the field at 000. A decoder that mis-maps a level, or that lets code 11 pick Gray code, yields wrong words. It then loads each unlisted field value with the strap at mid, so a design that falls back to the strap rather than to offset binary is caught. It pairs a write with a sample in the same cycle, which exposes a converter that reads the new field a cycle early. It pulses the soft reset after nonzero output and then checks that the stored fields and the two's complement conversion survive, which catches a reset wired into the control register. A write to a neighbouring address checks address decoding, and idle cycles check that `out_data` holds its last value.

// File: rtl/adc_fmt_sel_pkg.sv
package adc_fmt_sel_pkg;

  typedef enum logic [1:0] {
    CODE_OFFSET = 2'd0,
    CODE_TWOS   = 2'd1,
    CODE_GRAY   = 2'd2
  } code_e;

  localparam logic [2:0] FLD_STRAP  = 3'b000;
  localparam logic [2:0] FLD_TWOS   = 3'b001;
  localparam logic [2:0] FLD_GRAY   = 3'b010;
  localparam logic [2:0] FLD_OFFSET = 3'b100;

  localparam logic [1:0] STRAP_LOW  = 2'b00;
  localparam logic [1:0] STRAP_MID  = 2'b01;
  localparam logic [1:0] STRAP_HIGH = 2'b10;

  typedef struct packed {
    logic [2:0] drv;
    logic [2:0] fmt;
  } ctrl_t;

endpackage

// File: rtl/adc_fmt_ctrl_reg.sv
module adc_fmt_ctrl_reg
  import adc_fmt_sel_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h1A,
  parameter int FMT_LSB   = 0,
  parameter int DRV_LSB   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             ctrl
);

  logic hit;
  assign hit = wr_en && (wr_addr == CTRL_ADDR);

  // soft reset deliberately not an input: the fields survive it
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (hit) begin
      ctrl.fmt <= wr_data[FMT_LSB +: 3];
      ctrl.drv <= wr_data[DRV_LSB +: 3];
    end
  end

endmodule

// File: rtl/adc_fmt_code_pick.sv
module adc_fmt_code_pick
  import adc_fmt_sel_pkg::*;
(
  input  logic [2:0] fmt,
  input  logic [1:0] strap_lvl,
  output code_e      code
);

  code_e strap_code;

  always_comb begin
    case (strap_lvl)
      STRAP_MID:  strap_code = CODE_TWOS;
      STRAP_HIGH: strap_code = CODE_GRAY;
      default:    strap_code = CODE_OFFSET;
    endcase
  end

  always_comb begin
    case (fmt)
      FLD_STRAP:  code = strap_code;
      FLD_TWOS:   code = CODE_TWOS;
      FLD_GRAY:   code = CODE_GRAY;
      default:    code = CODE_OFFSET;
    endcase
  end

endmodule

// File: rtl/adc_fmt_convert.sv
module adc_fmt_convert
  import adc_fmt_sel_pkg::*;
#(
  parameter int W = 12
) (
  input  code_e        code,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] twos_w;
  logic [W-1:0] gray_w;

  assign twos_w = {~din[W-1], din[W-2:0]};

  genvar i;
  generate
    for (i = 0; i < W - 1; i++) begin : g_gray
      assign gray_w[i] = din[i] ^ din[i+1];
    end
  endgenerate
  assign gray_w[W-1] = din[W-1];

  always_comb begin
    case (code)
      CODE_TWOS: dout = twos_w;
      CODE_GRAY: dout = gray_w;
      default:   dout = din;
    endcase
  end

endmodule

// File: rtl/adc_fmt_sel.sv
module adc_fmt_sel
  import adc_fmt_sel_pkg::*;
#(
  parameter int W      = 12,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h1A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        strap_lvl,
  input  logic              smp_valid,
  input  logic [W-1:0]      smp_data,
  output logic              out_valid,
  output logic [W-1:0]      out_data,
  output logic [2:0]        fmt_field,
  output logic [2:0]        drv_mode
);

  ctrl_t        ctrl;
  code_e        code;
  logic [W-1:0] conv;

  adc_fmt_ctrl_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR),
    .FMT_LSB(0), .DRV_LSB(4)
  ) u_reg (
    .clk(clk), .rst(rst), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ctrl(ctrl)
  );

  adc_fmt_code_pick u_pick (
    .fmt(ctrl.fmt), .strap_lvl(strap_lvl), .code(code)
  );

  adc_fmt_convert #(.W(W)) u_conv (
    .code(code), .din(smp_data), .dout(conv)
  );

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= smp_valid;
      if (smp_valid) out_data <= conv;
    end
  end

  assign fmt_field = ctrl.fmt;
  assign drv_mode  = ctrl.drv;

endmodule

// File: rtl/adc_fmt_sel_chk.sv
module adc_fmt_sel_chk #(
  parameter int W      = 12,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 8'h1A
) (
  input logic              clk,
  input logic              rst,
  input logic              soft_rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              smp_valid,
  input logic [W-1:0]      smp_data,
  input logic              out_valid,
  input logic [W-1:0]      out_data,
  input logic [2:0]        fmt_field,
  input logic [2:0]        drv_mode
);

  localparam logic [W-1:0] TOP_BIT = {1'b1, {(W-1){1'b0}}};

  AST_HARD_CLEAR: assert property (@(posedge clk)
    rst |=> (fmt_field == 3'b000 && drv_mode == 3'b000 && !out_valid && out_data == '0)); // R1

  AST_CTRL_LOAD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == CTRL_ADDR) |=>
      (fmt_field == $past(wr_data[2:0]) && drv_mode == $past(wr_data[6:4]))); // R2

  AST_TWOS_CODE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(fmt_field) == 3'b001) |->
      (out_data == ($past(smp_data) ^ TOP_BIT))); // R3

  AST_GRAY_CODE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(fmt_field) == 3'b010) |->
      (out_data == ($past(smp_data) ^ ($past(smp_data) >> 1)))); // R4

  AST_OFFSET_CODE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(fmt_field) == 3'b100) |-> (out_data == $past(smp_data))); // R5

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    !soft_rst |=> (out_valid == $past(smp_valid))); // R8

  AST_SOFT_KEEP: assert property (@(posedge clk) disable iff (rst)
    (soft_rst && !wr_en) |=> ($stable(fmt_field) && $stable(drv_mode))); // R9

  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (!out_valid && out_data == '0)); // R9

endmodule

bind adc_fmt_sel adc_fmt_sel_chk #(
  .W(W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
) chk_i (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr_en(wr_en),
  .wr_addr(wr_addr), .wr_data(wr_data), .smp_valid(smp_valid),
  .smp_data(smp_data), .out_valid(out_valid), .out_data(out_data),
  .fmt_field(fmt_field), .drv_mode(drv_mode)
);

// File: tb/adc_fmt_sel_tb_top.sv
module adc_fmt_sel_tb_top;

  localparam int W = 12;
  localparam logic [7:0] CTRL = 8'h1A;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         soft_rst = 1'b0;
  logic         wr_en = 1'b0;
  logic [7:0]   wr_addr = '0;
  logic [7:0]   wr_data = '0;
  logic [1:0]   strap_lvl = 2'b00;
  logic         smp_valid = 1'b0;
  logic [W-1:0] smp_data = '0;
  logic         out_valid;
  logic [W-1:0] out_data;
  logic [2:0]   fmt_field;
  logic [2:0]   drv_mode;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [2:0]   cur_f = 3'b000;
  logic [W-1:0] last_exp = '0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #2 clk = ~clk;

  adc_fmt_sel dut_i (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .strap_lvl(strap_lvl),
    .smp_valid(smp_valid), .smp_data(smp_data), .out_valid(out_valid),
    .out_data(out_data), .fmt_field(fmt_field), .drv_mode(drv_mode)
  );

  function automatic logic [W-1:0] model(logic [2:0] f, logic [1:0] s, logic [W-1:0] x);
    int k;
    case (f)
      3'b001: k = 1;
      3'b010: k = 2;
      3'b000: k = (s == 2'b01) ? 1 : (s == 2'b10) ? 2 : 0;
      default: k = 0;
    endcase
    if (k == 1) return x ^ (1 << (W-1));
    if (k == 2) return x ^ (x >> 1);
    return x;
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, expv);
    end
  endtask

  task automatic send(logic [W-1:0] x, string tag);
    @(negedge clk);
    wr_en = 1'b0;
    smp_valid = 1'b1;
    smp_data = x;
    exp_q.push_back(model(cur_f, strap_lvl, x));
    tag_q.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_valid = 1'b0;
      wr_en = 1'b0;
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    smp_valid = 1'b0;
    wr_en = 1'b1;
    wr_addr = a;
    wr_data = d;
    if (a == CTRL) cur_f = d[2:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic burst(string tag);
    send(12'h000, tag); send(12'hFFF, tag); send(12'h800, tag);
    send(12'h7FF, tag); send(12'h5A3, tag); send(12'h3C6, tag);
    idle(2);
  endtask

  // monitor: pops expected items as results appear
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && out_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected valid", 1, 0);
        end else begin
          logic [W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          last_exp = e;
          check(out_data === e, t, int'(out_data), int'(e));
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=1 exp=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(fmt_field == 3'b000 && drv_mode == 3'b000, "R1 fields after reset",
          int'({drv_mode, fmt_field}), 0);
    check(!out_valid && out_data == '0, "R1 output after reset", int'(out_data), 0);

    // R6: strap levels with field 000
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      strap_lvl = 2'(s);
      burst("R6 strap decode");
    end

    // R2 / R10 / R3
    strap_lvl = 2'b10;
    wr(CTRL, 8'h21);
    check(fmt_field == 3'b001, "R2 fmt load", int'(fmt_field), 1);
    check(drv_mode == 3'b010, "R10 drv LVDS 3mA", int'(drv_mode), 2);
    burst("R3 twos complement");

    wr(8'h1B, 8'h42);
    check(fmt_field == 3'b001 && drv_mode == 3'b010, "R2 other address ignored",
          int'({drv_mode, fmt_field}), 8'h11);

    wr(CTRL, 8'h12);
    check(drv_mode == 3'b001, "R10 drv LVDS 2mA", int'(drv_mode), 1);
    burst("R4 gray code");

    wr(CTRL, 8'h44);
    check(drv_mode == 3'b100, "R10 drv LVCMOS", int'(drv_mode), 4);
    burst("R5 offset binary");

    // R7: unlisted values with strap at mid
    strap_lvl = 2'b01;
    wr(CTRL, 8'h03); burst("R7 field 011");
    wr(CTRL, 8'h05); burst("R7 field 101");
    wr(CTRL, 8'h06); burst("R7 field 110");
    wr(CTRL, 8'h07); burst("R7 field 111");

    // R11: write and sample in the same cycle
    wr(CTRL, 8'h02);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = CTRL; wr_data = 8'h01;
    smp_valid = 1'b1; smp_data = 12'h9C4;
    exp_q.push_back(model(cur_f, strap_lvl, 12'h9C4));
    tag_q.push_back("R11 same-cycle sample keeps old format");
    cur_f = 3'b001;
    send(12'h9C4, "R11 next sample uses new format");
    idle(3);

    // R8: hold while idle
    check(!out_valid, "R8 valid drops", int'(out_valid), 0);
    check(out_data == last_exp, "R8 data holds", int'(out_data), int'(last_exp));

    // R9: soft reset
    wr(CTRL, 8'h11);
    send(12'h123, "R9 pre soft reset");
    idle(2);
    @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    check(out_data == '0 && !out_valid, "R9 output flushed", int'(out_data), 0);
    check(fmt_field == 3'b001 && drv_mode == 3'b001, "R9 fields kept",
          int'({drv_mode, fmt_field}), 8'h09);
    burst("R9 format after soft reset");

    // R1: hard reset clears fields
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(fmt_field == 3'b000 && drv_mode == 3'b000, "R1 hard reset clears",
          int'({drv_mode, fmt_field}), 0);
    check(exp_q.size() == 0, "R8 all samples returned", exp_q.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule